// File: doc/BRIEF.md
# GPIO Port with Grouped Interrupt Summary

This block is a 32-line general-purpose I/O port that is programmed through a simple single-cycle register port. Software chooses the direction of each pin, the value each output drives, and whether an output runs a self-timed square wave instead of a fixed level. Each input is synchronized to the block clock. It is then optionally inverted by a per-pin polarity bit, and the result is readable as the corrected input.

The corrected input drives two interrupt paths. The level path uses the corrected input as it is, gated by a level mask. The edge path latches every low-to-high change of the corrected input into a sticky cause bit, gated by an edge mask. Software chooses a rising or a falling edge through the polarity bit. The per-pin interrupts are ORed in blocks of eight consecutive pins, and each block drives one summary line toward an interrupt controller. Pads, tristate buffers and the controller itself sit outside the block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every direction bit is 1 (input), and the output, blink, polarity, edge-cause, edge-mask and level-mask registers are all zero. Every summary line and every pad output is therefore 0.
- R2: The register port decodes byte offset bits [4:2]. The offsets are 0x00 direction, 0x04 output value, 0x08 blink enable, 0x0C polarity, 0x10 corrected input (read-only), 0x14 edge cause, 0x18 edge mask and 0x1C level mask. A write takes effect at the clock edge, a read returns the selected register combinationally, and a write to 0x10 changes nothing.
- R3: Reading 0x10 returns the pad input delayed through two clock edges and XORed with the polarity register. A pad change becomes visible after the second edge.
- R4: An edge-cause bit is set on the clock edge that follows the first cycle in which its corrected input reads 1 after having read 0. It then stays set, whatever the input does, until software clears it.
- R5: A write to 0x14 clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R6: If a new edge event and a clearing write reach the same cause bit in the same cycle, the bit ends up set.
- R7: The level interrupt of a pin is its corrected input ANDed with its level-mask bit. It holds no state and drops as soon as the corrected input falls.
- R8: Summary output g is the OR, over pins 8g to 8g+7, of (corrected input AND level mask) OR (edge cause AND edge mask).
- R9: A pad output equals its output-register bit while its blink bit is 0. While the blink bit is 1 it follows a shared square wave. That wave starts low at reset, first toggles on the BLINK_HALF-th clock edge after reset, and toggles every BLINK_HALF edges after that.
- R10: The direction output presents the direction register, with 1 meaning input, and changes only on a write to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 5 | Byte offset of the addressed register |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | NUM_PINS | Write data |
| busRdData | output | NUM_PINS | Read data for the addressed register |
| padIn | input | NUM_PINS | Raw pin levels from the pads |
| padOut | output | NUM_PINS | Value to drive on each pin |
| padInputMode | output | NUM_PINS | Per-pin direction, 1 = input (driver off) |
| groupIrq | output | NUM_PINS/8 | One interrupt summary per block of eight pins |

## Verification
The bench aims a cause clear at the exact cycle in which a new edge arrives on the same pin. A design where the clear takes priority loses that event, and the read-back after it shows 0. It acknowledges one pin with an all-ones-but-one write while a second pin is pending. A design that treats the write as a plain store, or that clears on 1, either wipes the second cause or keeps the first. It drops a level-masked input and expects the summary line to fall two edges later; a design that latches level events keeps the line high. It also times the corrected input against both synchronizer edges, writes to the read-only input register, and counts blink toggles over a fixed window, so an off-by-one delay or prescaler shows up.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Byte offset width of the register window (eight 32-bit words).
  localparam int REG_ADDR_W = 5;

  // Word index of each register, taken from offset bits [4:2].
  typedef enum logic [2:0] {
    REG_DIR   = 3'd0,
    REG_OUT   = 3'd1,
    REG_BLINK = 3'd2,
    REG_POL   = 3'd3,
    REG_DIN   = 3'd4,
    REG_CAUSE = 3'd5,
    REG_EMASK = 3'd6,
    REG_LMASK = 3'd7
  } regSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic    wrDir;
    logic    wrOut;
    logic    wrBlink;
    logic    wrPol;
    logic    wrCause;
    logic    wrEdgeMask;
    logic    wrLevelMask;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  output busStrobe_t            strobe
);

  regSel_e wordSel;
  logic    unusedByteBits;

  assign wordSel        = regSel_e'(busAddr[REG_ADDR_W-1:2]);
  assign unusedByteBits = ^busAddr[1:0];

  always_comb begin
    strobe             = '0;
    strobe.rdSel       = wordSel;
    if (busWrEn) begin
      case (wordSel)
        REG_DIR:   strobe.wrDir       = 1'b1;
        REG_OUT:   strobe.wrOut       = 1'b1;
        REG_BLINK: strobe.wrBlink     = 1'b1;
        REG_POL:   strobe.wrPol       = 1'b1;
        REG_CAUSE: strobe.wrCause     = 1'b1;
        REG_EMASK: strobe.wrEdgeMask  = 1'b1;
        REG_LMASK: strobe.wrLevelMask = 1'b1;
        default:   ; // corrected input is read-only
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_blink_tmr.sv
module gpio_blink_tmr #(
  parameter int BLINK_HALF = 1000
) (
  input  logic clk,
  input  logic rstN,
  output logic blinkPhase
);

  localparam int CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_HALF - 1);

  logic [CNT_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      blinkPhase <= 1'b0;
    end else if (preCnt == CNT_LAST) begin
      preCnt     <= '0;
      blinkPhase <= ~blinkPhase;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int BLINK_HALF  = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobe_t            strobe,
  input  logic [NUM_PINS-1:0]   wrData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   rdData,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padInputMode,
  output logic [NUM_GROUPS-1:0] groupIrq,
  output logic [NUM_PINS-1:0]   corrIn,
  output logic [NUM_PINS-1:0]   edgeCause,
  output logic [NUM_PINS-1:0]   edgeMask,
  output logic [NUM_PINS-1:0]   levelMask,
  output logic [NUM_PINS-1:0]   blinkEn
);

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] outReg;
  logic [NUM_PINS-1:0] polReg;
  logic [NUM_PINS-1:0] prevCorr;
  logic [NUM_PINS-1:0] syncIn;
  logic [NUM_PINS-1:0] riseEvt;
  logic [NUM_PINS-1:0] pinIrq;
  logic                blinkPhase;

  gpio_irq_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(padIn),
    .syncOut(syncIn)
  );

  gpio_blink_tmr #(
    .BLINK_HALF(BLINK_HALF)
  ) i_blink (
    .clk       (clk),
    .rstN      (rstN),
    .blinkPhase(blinkPhase)
  );

  assign corrIn  = syncIn ^ polReg;
  assign riseEvt = corrIn & ~prevCorr;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg    <= '1;
      outReg    <= '0;
      blinkEn   <= '0;
      polReg    <= '0;
      edgeMask  <= '0;
      levelMask <= '0;
    end else begin
      if (strobe.wrDir)       dirReg    <= wrData;
      if (strobe.wrOut)       outReg    <= wrData;
      if (strobe.wrBlink)     blinkEn   <= wrData;
      if (strobe.wrPol)       polReg    <= wrData;
      if (strobe.wrEdgeMask)  edgeMask  <= wrData;
      if (strobe.wrLevelMask) levelMask <= wrData;
    end
  end

  // Sticky edge cause: zeros in the write clear, new events win.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCorr  <= '0;
      edgeCause <= '0;
    end else begin
      prevCorr  <= corrIn;
      edgeCause <= (strobe.wrCause ? (edgeCause & wrData) : edgeCause) | riseEvt;
    end
  end

  assign padOut       = (blinkEn & {NUM_PINS{blinkPhase}}) | (outReg & ~blinkEn);
  assign padInputMode = dirReg;
  assign pinIrq       = (corrIn & levelMask) | (edgeCause & edgeMask);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign groupIrq[g] = |pinIrq[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_comb begin
    case (strobe.rdSel)
      REG_DIR:   rdData = dirReg;
      REG_OUT:   rdData = outReg;
      REG_BLINK: rdData = blinkEn;
      REG_POL:   rdData = polReg;
      REG_DIN:   rdData = corrIn;
      REG_CAUSE: rdData = edgeCause;
      REG_EMASK: rdData = edgeMask;
      default:   rdData = levelMask;
    endcase
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int BLINK_HALF  = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  input  logic [NUM_PINS-1:0]   busWrData,
  output logic [NUM_PINS-1:0]   busRdData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padInputMode,
  output logic [NUM_GROUPS-1:0] groupIrq
);

  busStrobe_t          strobe;
  logic [NUM_PINS-1:0] corrIn;
  logic [NUM_PINS-1:0] edgeCause;
  logic [NUM_PINS-1:0] edgeMask;
  logic [NUM_PINS-1:0] levelMask;
  logic [NUM_PINS-1:0] blinkEn;

  gpio_irq_ctrl i_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  gpio_irq_dp #(
    .NUM_PINS   (NUM_PINS),
    .GROUP_SIZE (GROUP_SIZE),
    .BLINK_HALF (BLINK_HALF),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (busWrData),
    .padIn       (padIn),
    .rdData      (busRdData),
    .padOut      (padOut),
    .padInputMode(padInputMode),
    .groupIrq    (groupIrq),
    .corrIn      (corrIn),
    .edgeCause   (edgeCause),
    .edgeMask    (edgeMask),
    .levelMask   (levelMask),
    .blinkEn     (blinkEn)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic [2:0]            wordIdx,
  input logic [NUM_PINS-1:0]   busWrData,
  input logic [NUM_PINS-1:0]   corrIn,
  input logic [NUM_PINS-1:0]   edgeCause,
  input logic [NUM_PINS-1:0]   edgeMask,
  input logic [NUM_PINS-1:0]   levelMask,
  input logic [NUM_PINS-1:0]   blinkEn,
  input logic [NUM_PINS-1:0]   padOut,
  input logic [NUM_PINS-1:0]   padInputMode,
  input logic [NUM_GROUPS-1:0] groupIrq
);

  logic [NUM_PINS-1:0] corrSeen;
  logic [NUM_PINS-1:0] riseSeen;
  logic                causeWr;
  logic                otherWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrSeen <= '0;
      riseSeen <= '0;
    end else begin
      corrSeen <= corrIn;
      riseSeen <= corrIn & ~corrSeen;
    end
  end

  assign causeWr = busWrEn && (wordIdx == REG_CAUSE);
  assign otherWr = busWrEn && ((wordIdx == REG_OUT) || (wordIdx == REG_BLINK));

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !causeWr |=> ((edgeCause & $past(edgeCause)) == $past(edgeCause))); // R4

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeCause & riseSeen) == riseSeen)); // R6

  AST_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    causeWr |=> ((edgeCause & ~$past(busWrData) & ~riseSeen) == '0)); // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((levelMask == '0) && (edgeMask == '0)) |-> (groupIrq == '0)); // R8

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && (wordIdx == REG_DIR)) |=> $stable(padInputMode)); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!otherWr && (blinkEn == '0)) |=> $stable(padOut)); // R9

endmodule

bind gpio_irq_port gpio_irq_chk #(
  .NUM_PINS  (NUM_PINS),
  .NUM_GROUPS(NUM_GROUPS)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busWrEn     (busWrEn),
  .wordIdx     (busAddr[4:2]),
  .busWrData   (busWrData),
  .corrIn      (corrIn),
  .edgeCause   (edgeCause),
  .edgeMask    (edgeMask),
  .levelMask   (levelMask),
  .blinkEn     (blinkEn),
  .padOut      (padOut),
  .padInputMode(padInputMode),
  .groupIrq    (groupIrq)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 32;
  localparam int NG         = 4;
  localparam int HALF       = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [NP-1:0] busWrData = '0;
  logic [NP-1:0] busRdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut;
  logic [NP-1:0] padInputMode;
  logic [NG-1:0] groupIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port #(.NUM_PINS(NP), .GROUP_SIZE(8), .BLINK_HALF(HALF), .SYNC_STAGES(2)) i_gpio_irq_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padInputMode(padInputMode), .groupIrq(groupIrq)
  );

  // Reference model built from the requirements
  logic [NP-1:0] mDir, mOut, mBlink, mPol, mCause, mEm, mLm, mS1, mS2, mPrev;
  int            mCnt;
  logic          mPhase;

  function automatic logic [NP-1:0] mCorr();
    return mS2 ^ mPol;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir <= '1; mOut <= '0; mBlink <= '0; mPol <= '0; mCause <= '0;
      mEm <= '0; mLm <= '0; mS1 <= '0; mS2 <= '0; mPrev <= '0;
      mCnt <= 0; mPhase <= 1'b0;
    end else begin
      mS1   <= padIn;
      mS2   <= mS1;
      mPrev <= mCorr();
      mCause <= ((busWrEn && busAddr[4:2] == 3'd5) ? (mCause & busWrData) : mCause)
                | (mCorr() & ~mPrev);
      if (busWrEn) begin
        case (busAddr[4:2])
          3'd0: mDir   <= busWrData;
          3'd1: mOut   <= busWrData;
          3'd2: mBlink <= busWrData;
          3'd3: mPol   <= busWrData;
          3'd6: mEm    <= busWrData;
          3'd7: mLm    <= busWrData;
          default: ;
        endcase
      end
      if (mCnt == HALF - 1) begin
        mCnt <= 0; mPhase <= ~mPhase;
      end else mCnt <= mCnt + 1;
    end
  end

  function automatic logic [NP-1:0] mRead(input logic [4:0] a);
    case (a[4:2])
      3'd0: return mDir;
      3'd1: return mOut;
      3'd2: return mBlink;
      3'd3: return mPol;
      3'd4: return mCorr();
      3'd5: return mCause;
      3'd6: return mEm;
      default: return mLm;
    endcase
  endfunction

  function automatic logic [NG-1:0] mGrp();
    logic [NP-1:0] p;
    logic [NG-1:0] g;
    p = (mCorr() & mLm) | (mCause & mEm);
    for (int i = 0; i < NG; i++) g[i] = |p[i*8 +: 8];
    return g;
  endfunction

  function automatic logic [NP-1:0] mPad();
    return (mBlink & {NP{mPhase}}) | (mOut & ~mBlink);
  endfunction

  function automatic string tagFor(input logic [4:0] a);
    if (a[4:2] == 3'd4) return "R3";
    if (a[4:2] == 3'd5) return "R4";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, check the read, advance, check outputs.
  task automatic cyc(input logic we, input logic [4:0] a, input logic [NP-1:0] d,
                     input logic [NP-1:0] pin);
    busWrEn = we; busAddr = a; busWrData = d; padIn = pin;
    #1;
    if (!we) chk(tagFor(a), busRdData, mRead(a));
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
    chk("R8", NP'(groupIrq), NP'(mGrp()));
    chk("R9", padOut, mPad());
    chk("R10", padInputMode, mDir);
  endtask

  task automatic rd(input logic [4:0] a, input logic [NP-1:0] exp, input string req);
    busWrEn = 1'b0; busAddr = a;
    #1;
    chk(req, busRdData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] pins;
    int toggles;
    logic lastBit;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(5'h00, '1, "R1");
    rd(5'h04, '0, "R1");
    rd(5'h08, '0, "R1");
    rd(5'h0C, '0, "R1");
    rd(5'h14, '0, "R1");
    rd(5'h18, '0, "R1");
    rd(5'h1C, '0, "R1");
    chk("R1", NP'(groupIrq), '0);
    chk("R1", padOut, '0);
    rstN = 1'b1;

    // R2: readback and read-only input register
    cyc(1, 5'h04, 32'hA5A5_0F0F, '0);
    rd(5'h04, 32'hA5A5_0F0F, "R2");
    cyc(1, 5'h10, 32'hFFFF_FFFF, '0);
    rd(5'h10, '0, "R2");
    cyc(1, 5'h00, 32'h0000_FFFF, '0);
    chk("R10", padInputMode, 32'h0000_FFFF);

    // R3: polarity and two-edge latency
    cyc(1, 5'h0C, 32'h0000_0010, '0);
    rd(5'h10, 32'h0000_0010, "R3");
    cyc(0, 5'h10, '0, 32'h0000_0001);
    rd(5'h10, 32'h0000_0010, "R3");
    cyc(0, 5'h10, '0, 32'h0000_0001);
    rd(5'h10, 32'h0000_0011, "R3");
    cyc(1, 5'h0C, '0, '0);
    cyc(0, 5'h10, '0, '0);
    cyc(0, 5'h10, '0, '0);
    cyc(1, 5'h14, '0, '0);
    rd(5'h14, '0, "R5");

    // R6: clear lands in the same cycle as a new edge on pin 3
    cyc(0, 5'h10, '0, 32'h8);
    cyc(0, 5'h10, '0, 32'h8);
    cyc(1, 5'h14, 32'hFFFF_FFF7, 32'h8);
    rd(5'h14, 32'h8, "R6");
    // R5: acknowledge pin 3 while pin 5 stays pending
    cyc(0, 5'h10, '0, 32'h28);
    cyc(0, 5'h10, '0, 32'h28);
    cyc(0, 5'h10, '0, 32'h28);
    rd(5'h14, 32'h28, "R4");
    cyc(1, 5'h14, 32'hFFFF_FFF7, 32'h28);
    rd(5'h14, 32'h20, "R5");
    // R4: sticky after the input falls
    cyc(0, 5'h10, '0, '0);
    cyc(0, 5'h10, '0, '0);
    cyc(0, 5'h10, '0, '0);
    rd(5'h14, 32'h20, "R4");
    cyc(1, 5'h14, '0, '0);

    // R7: level interrupt follows the input, no latching
    cyc(1, 5'h1C, 32'h0000_0200, '0);
    cyc(0, 5'h10, '0, 32'h0000_0200);
    chk("R7", NP'(groupIrq), '0);
    cyc(0, 5'h10, '0, 32'h0000_0200);
    chk("R7", NP'(groupIrq), NP'(4'b0010));
    cyc(0, 5'h10, '0, '0);
    cyc(0, 5'h10, '0, '0);
    chk("R7", NP'(groupIrq), '0);
    cyc(1, 5'h1C, '0, '0);

    // R8: edge-masked cause on pin 30 reaches group 3
    cyc(1, 5'h18, 32'h4000_0000, '0);
    cyc(0, 5'h10, '0, 32'h4000_0000);
    cyc(0, 5'h10, '0, 32'h4000_0000);
    cyc(0, 5'h10, '0, '0);
    chk("R8", NP'(groupIrq), NP'(4'b1000));
    cyc(1, 5'h14, '0, '0);
    chk("R8", NP'(groupIrq), '0);
    cyc(1, 5'h18, '0, '0);

    // R9: blink toggles once per HALF edges
    cyc(1, 5'h08, 32'h4, '0);
    toggles = 0;
    lastBit = padOut[2];
    for (int i = 0; i < 4 * HALF; i++) begin
      cyc(0, 5'h08, '0, '0);
      if (padOut[2] != lastBit) toggles++;
      lastBit = padOut[2];
    end
    chk("R9", NP'(toggles), NP'(4));
    cyc(1, 5'h08, '0, '0);

    // Random traffic checked against the model
    pins = '0;
    for (int n = 0; n < 4000; n++) begin
      logic [4:0]    a;
      logic [NP-1:0] d;
      logic          we;
      if ($urandom_range(3) == 0) pins ^= NP'(1) << $urandom_range(NP-1);
      a  = {3'($urandom_range(7)), 2'b00};
      we = ($urandom_range(9) < 6);
      d  = $urandom;
      if (a[4:2] == 3'd5 && $urandom_range(1) == 0) d = ~(NP'(1) << $urandom_range(NP-1));
      cyc(we, a, d, pins);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule